// File: doc/BRIEF.md
# Pipelined Ternary-Tree Flow Identifier Search

This block answers one question per request: is a given 96-bit flow identifier stored in a sorted search tree? Every tree node fills one 256-bit memory word. The word holds two ordered keys and three child pointers, so each node splits the key space into three ranges. Each tree level has its own memory bank inside the block. A lookup visits the levels in turn, one bank per level. While one lookup reads level 2, the lookup behind it can read level 1 and a newer one can read the root. A new request may therefore enter on every clock cycle.

The banks are synchronous RAMs with a fixed read latency. They are filled through a load port, one node word per cycle, addressed by level and node index. Every search starts at node 0 of level 0. Each request carries a tag, and its hit/miss answer comes out after a fixed number of cycles, in the order the requests were issued.

Top module: `flow_lookup_top`

## Requirements
- R1: A node word is packed from bit 0 upward as: key A in bits 95:0, key B in bits 191:96, low child in bits 211:192, middle child in bits 231:212, high child in bits 251:232. Bits 255:252 are ignored.
- R2: At a node, a search key below key A continues at the low child. A key above A and below B continues at the middle child. A key above B continues at the high child. Each child pointer indexes a node in the next level's bank.
- R3: A search key equal to key A or key B of a visited node gives a hit. Later levels do not change that result.
- R4: A child pointer of all ones (20'hFFFFF) is null. Following a null pointer ends the search as a miss, and later levels leave the miss unchanged.
- R5: A response appears exactly LEVELS×RD_LAT cycles after its request was accepted (8 by default). It carries the request's tag unchanged, and responses keep issue order.
- R6: Requests may be issued on consecutive cycles with no gap, and each one still gets its own correct response.
- R7: While reset is held, and on the first cycle after it is released, rsp_valid is 0.
- R8: A search that passes through all levels with no matching key reports a miss.
- R9: When ld_en is high, the load port writes ld_word into the bank selected by ld_level (0 is the root level), at the node index ld_addr. Every search starts at node 0 of level 0.
- R10: A cycle with req_valid low produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Write one node word this cycle |
| ld_level | input | 2 | Tree level (bank) to write |
| ld_addr | input | 6 | Node index inside the bank |
| ld_word | input | 256 | Packed node word |
| req_valid | input | 1 | Lookup request present |
| req_key | input | 96 | Flow identifier to search for |
| req_tag | input | 8 | Tag returned with the result |
| rsp_valid | output | 1 | Result present |
| rsp_tag | output | 8 | Tag of the finished lookup |
| rsp_hit | output | 1 | 1 if the identifier is in the tree |

## Verification
The bench loads a full four-level tree of 80 keys. It checks keys at the extremes of the key range and keys equal to either root key. A design that mixed up key A and key B, or used a non-strict comparison, would route these keys down the wrong branch and report a miss. It also checks keys that fall strictly between two stored keys, and keys whose high part matches a stored key but whose low 64 bits differ. A comparator that looks at only part of the key would report a false hit on these.

The bench then sets one inner child pointer to null. The whole subtree under that pointer must turn into misses. A design that ignores the null marker, or lets a later level overwrite the result, would report hits there.

Back-to-back random requests with scattered idle cycles check tag order and exact latency. A context pipeline that drifts by one cycle from its bank data would mix up the results of neighbouring requests.

// File: rtl/flow_lkp_pkg.sv
package flow_lkp_pkg;

    localparam int KEY_W  = 96;
    localparam int PTR_W  = 20;
    localparam int WORD_W = 256;
    localparam int TAG_W  = 8;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam ptr_t PTR_NULL = '1;

    typedef struct packed {
        key_t ka;
        key_t kb;
        ptr_t lo;
        ptr_t mid;
        ptr_t hi;
    } node_t;

    typedef struct packed {
        logic valid;
        logic done;
        logic hit;
        key_t key;
        ptr_t ptr;
        tag_t tag;
    } ctx_t;

    function automatic node_t unpack_node(word_t w);
        node_t n;
        n.ka  = w[95:0];
        n.kb  = w[191:96];
        n.lo  = w[211:192];
        n.mid = w[231:212];
        n.hi  = w[251:232];
        return n;
    endfunction

    function automatic ctx_t visit_node(ctx_t c, node_t n);
        ctx_t o;
        o = c;
        if (c.valid && !c.done) begin
            if (c.ptr == PTR_NULL) begin
                o.done = 1'b1;
                o.hit  = 1'b0;
            end else if (c.key == n.ka || c.key == n.kb) begin
                o.done = 1'b1;
                o.hit  = 1'b1;
                o.ptr  = PTR_NULL;
            end else if (c.key < n.ka) begin
                o.ptr = n.lo;
            end else if (c.key < n.kb) begin
                o.ptr = n.mid;
            end else begin
                o.ptr = n.hi;
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/flow_lkp_bank.sv
module flow_lkp_bank
    import flow_lkp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RD_LAT = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    word_t mem  [DEPTH];
    word_t pipe [RD_LAT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        pipe[0] <= mem[rd_addr];
        for (int i = 1; i < RD_LAT; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign rd_data = pipe[RD_LAT-1];

endmodule

// File: rtl/flow_lkp_stage.sv
module flow_lkp_stage
    import flow_lkp_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RD_LAT = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  word_t         ld_word,
    input  ctx_t          ctx_in,
    output ctx_t          ctx_out
);

    ctx_t  cq [RD_LAT];
    word_t node_word;
    node_t nd;
    ctx_t  tail;

    flow_lkp_bank #(.DEPTH(DEPTH), .RD_LAT(RD_LAT)) bank_i (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_word),
        .rd_addr (ctx_in.ptr[AW-1:0]),
        .rd_data (node_word)
    );

    // Context travels alongside the bank read so both arrive together.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) begin
                cq[i] <= '0;
            end
        end else begin
            cq[0] <= ctx_in;
            for (int i = 1; i < RD_LAT; i++) begin
                cq[i] <= cq[i-1];
            end
        end
    end

    assign tail    = cq[RD_LAT-1];
    assign nd      = unpack_node(node_word);
    assign ctx_out = visit_node(tail, nd);

    // R6: an accepted context is in the delay line on the next cycle
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        ctx_in.valid |=> cq[0].valid);

    // R3: a new hit only when the key matches a stored key of this node
    p_hit_match_r3: assert property (@(posedge clk) disable iff (rst)
        (ctx_out.valid && ctx_out.hit && !tail.done)
            |-> (tail.key == nd.ka || tail.key == nd.kb));

    // R4: a finished search passes through untouched
    p_done_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tail.valid && tail.done)
            |-> (ctx_out.done && ctx_out.hit == tail.hit));

    // R4: a null pointer ends the search as a miss
    p_null_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (tail.valid && !tail.done && tail.ptr == PTR_NULL)
            |-> (ctx_out.done && !ctx_out.hit));

endmodule

// File: rtl/flow_lookup_top.sv
module flow_lookup_top
    import flow_lkp_pkg::*;
#(
    parameter int LEVELS  = 4,
    parameter int DEPTH   = 64,
    parameter int RD_LAT  = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int LAT    = LEVELS * RD_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [LVL_W-1:0] ld_level,
    input  logic [AW-1:0]    ld_addr,
    input  logic [255:0]     ld_word,
    input  logic             req_valid,
    input  logic [95:0]      req_key,
    input  logic [7:0]       req_tag,
    output logic             rsp_valid,
    output logic [7:0]       rsp_tag,
    output logic             rsp_hit
);

    ctx_t link [LEVELS+1];

    always_comb begin
        link[0]       = '0;
        link[0].valid = req_valid;
        link[0].key   = req_key;
        link[0].ptr   = '0;
        link[0].tag   = req_tag;
    end

    for (genvar s = 0; s < LEVELS; s++) begin : g_lvl
        flow_lkp_stage #(.DEPTH(DEPTH), .RD_LAT(RD_LAT)) stage_i (
            .clk     (clk),
            .rst     (rst),
            .ld_en   (ld_en && (ld_level == LVL_W'(s))),
            .ld_addr (ld_addr),
            .ld_word (ld_word),
            .ctx_in  (link[s]),
            .ctx_out (link[s+1])
        );
    end

    assign rsp_valid = link[LEVELS].valid;
    assign rsp_tag   = link[LEVELS].tag;
    assign rsp_hit   = link[LEVELS].hit;

    // Reference delay line of request valid and tag for the latency checks
    logic chk_v [LAT];
    tag_t chk_t [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                chk_v[i] <= 1'b0;
                chk_t[i] <= '0;
            end
        end else begin
            chk_v[0] <= req_valid;
            chk_t[0] <= req_tag;
            for (int i = 1; i < LAT; i++) begin
                chk_v[i] <= chk_v[i-1];
                chk_t[i] <= chk_t[i-1];
            end
        end
    end

    // R5 R10: a response exactly LAT cycles after each request, none otherwise
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == chk_v[LAT-1]);

    // R5: tags emerge in issue order
    p_tag_order_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_tag == chk_t[LAT-1]));

    // R7: nothing comes out right after reset
    p_reset_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R8: a search that never finished is a miss
    p_end_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !link[LEVELS].done) |-> !rsp_hit);

endmodule

// File: tb/flow_lookup_top_tb_top.sv
module flow_lookup_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LV   = 4;
    localparam int LAT  = 8;
    localparam int NKEY = 80;
    localparam logic [19:0] NUL = 20'hFFFFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_en = 1'b0;
    logic [1:0]   ld_level = '0;
    logic [5:0]   ld_addr = '0;
    logic [255:0] ld_word = '0;
    logic         req_valid = 1'b0;
    logic [95:0]  req_key = '0;
    logic [7:0]   req_tag = '0;
    logic         rsp_valid;
    logic [7:0]   rsp_tag;
    logic         rsp_hit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit nulled = 0;
    bit done_flag = 0;

    logic [7:0] q_tag [2048];
    logic       q_hit [2048];
    int         q_due [2048];
    int         q_wr = 0;
    int         q_rd = 0;
    int         ntag = 0;

    flow_lookup_top dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_level(ld_level),
        .ld_addr(ld_addr), .ld_word(ld_word), .req_valid(req_valid),
        .req_key(req_key), .req_tag(req_tag), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_hit(rsp_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int pow3(int e);
        int v = 1;
        for (int i = 0; i < e; i++) v = v * 3;
        return v;
    endfunction

    function automatic logic [95:0] key_of(int r);
        return {32'(2 * r + 2), 64'h5A5A_C3C3_0000_0000 ^ 64'(r)};
    endfunction

    // Reference membership from the key numbering (R2 R3 R4 R8)
    function automatic bit ref_hit(logic [95:0] k);
        int up = int'(k[95:64]);
        int r;
        if (k[95:64] > 32'd1000 || up < 2 || up % 2 != 0) return 0;
        r = (up - 2) / 2;
        if (r >= NKEY) return 0;
        if (k[63:0] != (64'h5A5A_C3C3_0000_0000 ^ 64'(r))) return 0;
        if (nulled && r < pow3(LV - 2) - 1) return 0;
        return 1;
    endfunction

    // Node word per the R1 layout for node n of level l
    function automatic logic [255:0] node_word(int l, int n);
        int h = LV - l;
        int base = 0;
        int sub = pow3(h - 1);
        logic [19:0] p [3];
        for (int k = 0; k < l; k++) begin
            int c = (n / pow3(l - 1 - k)) % 3;
            base = base + c * pow3(LV - k - 1);
        end
        for (int c = 0; c < 3; c++) begin
            p[c] = (l == LV - 1) ? NUL : 20'(3 * n + c);
        end
        return {4'hF, p[2], p[1], p[0], key_of(base + 2 * (sub - 1) + 1),
                key_of(base + sub - 1)};
    endfunction

    task automatic load_node(int l, int n, logic [255:0] w);
        @(negedge clk);
        ld_en    = 1'b1;
        ld_level = 2'(l);
        ld_addr  = 6'(n);
        ld_word  = w;
        @(negedge clk);
        ld_en    = 1'b0;
    endtask

    task automatic issue(logic [95:0] k);
        @(negedge clk);
        req_valid = 1'b1;
        req_key   = k;
        req_tag   = 8'(ntag);
        q_tag[q_wr % 2048] = 8'(ntag);
        q_hit[q_wr % 2048] = ref_hit(k);
        q_due[q_wr % 2048] = cyc + LAT;
        q_wr++;
        ntag++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_flag && rsp_valid) begin
            checks++;
            if (q_rd == q_wr) begin
                failures++;
                $display("FAIL R10 unexpected response tag=%0h expected none", rsp_tag);
            end else begin
                if (rsp_tag != q_tag[q_rd % 2048] || cyc != q_due[q_rd % 2048]) begin
                    failures++;
                    $display("FAIL R5 R6 tag=%0h cyc=%0d expected tag=%0h cyc=%0d",
                             rsp_tag, cyc, q_tag[q_rd % 2048], q_due[q_rd % 2048]);
                end
                checks++;
                if (rsp_hit != q_hit[q_rd % 2048]) begin
                    failures++;
                    $display("FAIL R1 R2 R3 R4 R8 R9 tag=%0h hit=%0b expected %0b",
                             rsp_tag, rsp_hit, q_hit[q_rd % 2048]);
                end
                q_rd++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [95:0] k;
        logic [255:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7: quiet while in reset
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 rsp_valid=%0b in reset expected 0", rsp_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 rsp_valid=%0b after reset expected 0", rsp_valid);
        end

        // R9: load every level
        for (int l = 0; l < LV; l++) begin
            for (int n = 0; n < pow3(l); n++) begin
                load_node(l, n, node_word(l, n));
            end
        end

        // Directed corners, back to back (R2 R3 R6 R8)
        issue(key_of(0));
        issue(key_of(NKEY - 1));
        issue(key_of(26));
        issue(key_of(53));
        issue(96'd0);
        issue({32'd999, 64'd0});
        issue({32'd55, 64'd0});
        issue(key_of(40) ^ 96'd1);
        issue(key_of(NKEY));
        idle(3);

        // Constrained random mix with bubbles (R5 R6 R10)
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, NKEY + 5));
            int m = int'($urandom_range(0, 9));
            k = key_of(r);
            if (m == 7) k[64] = ~k[64];
            if (m == 8) k[3]  = ~k[3];
            issue(k);
            if ($urandom_range(0, 6) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(LAT + 4);

        // R4: null the low child of the first level-1 node
        w = node_word(1, 0);
        w[211:192] = NUL;
        load_node(1, 0, w);
        nulled = 1;
        for (int r = 0; r < 12; r++) issue(key_of(r));
        for (int i = 0; i < 60; i++) issue(key_of(int'($urandom_range(0, NKEY - 1))));
        idle(LAT + 4);

        // R10: every issued request answered, nothing extra
        checks++;
        if (q_rd != q_wr) begin
            failures++;
            $display("FAIL R10 responses=%0d expected %0d", q_rd, q_wr);
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule